// File: doc/BRIEF.md
# Rising-Edge-Cleared Up-Counter

This block is a free-running binary counter that advances on every rising edge of the system clock. A separate control input, which may be slow and unrelated to the clock, returns the count to zero. Only a low-to-high change of that input clears the count. A level that stays high does not. Holding the input high after a clear lets counting continue, and another clear needs the input to go low and then rise again.

The control input passes through a synchronizer of `SYNC_STAGES` flops, two by default. A history flop follows it, and comparing the last synchronizer stage with the history flop gives a pulse one clock wide. That pulse and the increment both feed the one sequential process that owns the count register. With the default depth, the count reads zero after the third rising clock edge, counted from the first edge that samples the input high after it was low.

The synchronizer and history flops come out of reset in the high state. An input that is already high when reset is released therefore looks like a level that was always there, and it does not produce a clear.

Top module: `edge_clear_counter`

## Requirements
- R1: When no clear is due, the count increases by exactly one on every rising clock edge.
- R2: Suppose `trig_in` is sampled high at clock edge N and was sampled low at edge N-1. Then `count` is zero after edge N+2 (default synchronizer depth of 2).
- R3: While `trig_in` stays high after a clear, `count` keeps increasing by one per edge and is not cleared again.
- R4: After `trig_in` has been sampled low on at least one clock edge, its next low-to-high change causes another clear, with the timing of R2.
- R5: A clear and an increment can be due on the same edge. The clear wins and `count` becomes 0, not 1.
- R6: The count wraps from 2^CNT_W-1 (4095 with the default width of 12) to 0 without any clear.
- R7: While `rst` is high, `count` is set to 0 on each edge. If `trig_in` is high during reset and stays high after it, no clear happens until `trig_in` has been sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Active-high synchronous power-on reset |
| trig_in | input | 1 | Asynchronous clear trigger; only its rising edge counts |
| count | output | CNT_W | Current count value |

## Verification
Two things can be due on the same clock edge: the ordinary increment and the clear derived from a rising edge of `trig_in`. In practice every clear is this collision, because the counter never stops. The bench raises `trig_in` after low stretches of random length and also in directed positions, including on top of a long run that crosses the wrap point. On the edge where the clear lands, it expects zero rather than the incremented value. The bench also holds `trig_in` high for long stretches, across and after reset, to show that a held level does not bring the clear back.

// File: rtl/edge_clear_counter.sv
module edge_clear_counter #(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_in,
  output logic [CNT_W-1:0] count
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   trig_seen;
  logic                   clr_pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= '1;
      trig_seen <= 1'b1;
    end else begin
      sync_q    <= {sync_q[TOP-1:0], trig_in};
      trig_seen <= sync_q[TOP];
    end
  end

  assign clr_pulse = sync_q[TOP] & ~trig_seen;

  always_ff @(posedge clk) begin
    if (rst || clr_pulse) count <= '0;
    else                  count <= count + 1'b1;
  end

endmodule

// File: rtl/edge_clear_counter_chk.sv
module edge_clear_counter_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         trig_in,
  input logic [W-1:0] count,
  input logic         clr_pulse
);

  logic [2:0] warm;

  always_ff @(posedge clk) begin
    if (rst)               warm <= '0;
    else if (warm != 3'd7) warm <= warm + 3'd1;
  end

  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    (warm >= 3'd1 && !$past(clr_pulse)) |-> count == W'($past(count) + 1'b1));

  p_edge_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (warm >= 3'd4 && $past(trig_in, 2) && !$past(trig_in, 3)) |-> clr_pulse);

  p_level_no_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (warm >= 3'd4 && clr_pulse) |-> ($past(trig_in, 2) && !$past(trig_in, 3)));

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    clr_pulse |=> !clr_pulse);

  p_clear_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (warm >= 3'd1 && $past(clr_pulse)) |-> count == '0);

  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (warm >= 3'd1 && $past(count) == {W{1'b1}}) |-> count == '0);

  p_reset_zero_r7: assert property (@(posedge clk)
    $past(rst) |-> count == '0);

endmodule

bind edge_clear_counter edge_clear_counter_chk #(.W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .trig_in  (trig_in),
  .count    (count),
  .clr_pulse(clr_pulse)
);

// File: tb/edge_clear_counter_bench.sv
module edge_clear_counter_bench;

  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         trig_in = 1'b0;
  logic [W-1:0] count;

  int    nvec = 0;
  int    nerr = 0;
  bit    done = 1'b0;

  logic [W-1:0] exp_cnt;
  logic [2:0]   hist;
  bit           seen_clr;
  string        tag;

  edge_clear_counter #(.CNT_W(W), .SYNC_STAGES(2)) u_edge_clear_counter (
    .clk    (clk),
    .rst    (rst),
    .trig_in(trig_in),
    .count  (count)
  );

  always #4 clk = ~clk;

  function automatic logic [W-1:0] next_val(logic [W-1:0] cur, bit clear);
    return clear ? '0 : W'(cur + 1'b1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      exp_cnt  <= '0;
      hist     <= 3'b111;
      seen_clr <= 1'b0;
      tag      <= "R7";
    end else begin
      if (hist[1] && !hist[2]) begin
        exp_cnt  <= next_val(exp_cnt, 1'b1);
        tag      <= seen_clr ? "R2 R4 R5" : "R2 R5";
        seen_clr <= 1'b1;
      end else begin
        exp_cnt <= next_val(exp_cnt, 1'b0);
        if (exp_cnt == {W{1'b1}}) tag <= "R6";
        else if (hist[1])         tag <= seen_clr ? "R3" : "R7";
        else                      tag <= "R1";
      end
      hist <= {hist[1:0], trig_in};
    end
  end

  task automatic check_now();
    nvec++;
    if (count !== exp_cnt) begin
      nerr++;
      $display("FAIL %s count=%0d expected=%0d", tag, count, exp_cnt);
    end
  endtask

  task automatic run(int n, bit lvl);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now();
      trig_in = lvl;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    trig_in = 1'b1;
    rst     = 1'b1;
    repeat (3) @(negedge clk);
    check_now();
    rst = 1'b0;
    run(12, 1'b1);
    run(3, 1'b0);
    run(25, 1'b1);
    run(1, 1'b0);
    run(10, 1'b1);
    run(4300, 1'b0);
    run(6, 1'b1);
    run(2, 1'b0);
    for (int k = 0; k < 900; k++) begin
      run(1 + int'($urandom_range(11)), 1'($urandom_range(1)));
    end
    trig_in = 1'b1;
    rst     = 1'b1;
    run(3, 1'b1);
    rst = 1'b0;
    run(8, 1'b1);
    run(2, 1'b0);
    run(6, 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog count=%0d expected=%0d", count, exp_cnt);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

endmodule